// File: doc/BRIEF.md
# Programmable Clock-Mode Controller

This block is the digital control side of a clock generator. A single 16-bit control word sits on a simple register bus. Software uses it to choose between a multiplied clock, which comes from a phase-locked loop, and a plain divided clock. The same word sets the multiplier ratio, the divide-by factor, PLL power and a lock wait. A read-only status bit in the word reports which source is actually driving the core.

A write that asks for the multiplied clock does not switch at once. It loads a lock timer from the word. The timer counts down in steps of a fixed number of input-clock cycles. Only when it expires does the block raise its status bit and move the clock-select output to the PLL source. A write that asks for the divided clock takes effect on the next edge and cancels any wait still running.

At reset the word is loaded from a preset chosen by three mode-select pins. If the preset asks for PLL clocking, a lock wait starts straight away. The analog loop, the oscillator and glitch-free switching of the clocks are outside this block.

Top module: `clkmode_ctl`

## Requirements
- R1: The word answers at bus address REG_ADDR (default 0x0058). A read with `bus_sel` high and a matching address returns the word; any other read returns 0. A write with a different address changes nothing.
- R2: Word layout: bit 0 is status (read-only), bit 1 is mode (1 = PLL, 0 = divider), bit 2 is PLL enable, bits 10:3 are the lock count, bit 11 is the half flag, and bits 15:12 are the multiplier field M. Bus writes to bit 0 are ignored.
- R3: During reset (synchronous, `rst_n` low) the word is loaded from `mode_pins` as follows, with status 0: 0→0x2026, 1→0x1026, 2→0x4026, 3→0x2826, 4→0x0000, 5→0x0800, 6→0x0026, 7→0x3026. A preset with mode 1 starts a lock wait using its own lock count.
- R4: A write with bit 1 set clears status, loads the lock count N and restarts the prescaler. While bit 2 is set, status and `clk_sel` rise exactly 16·(N+1) clock edges after the write edge. While bit 2 is clear, the timer does not advance.
- R5: A write with bit 1 clear makes status and `clk_sel` 0 from the next edge and cancels any lock wait. No later rise occurs until a new PLL write.
- R6: While status is 1, `pll_ratio_x2` is twice the PLL ratio: 2·(M+1) with the half flag clear, and M+1 with the half flag set. M=15 with the half flag set is reserved and gives 0. While status is 0, the output is 0.
- R7: `div_by4` equals bit 11 while status is 0 (1 = divide by 4, 0 = divide by 2), and is 0 while status is 1.
- R8: `pll_pwr` is high only when both bit 1 and bit 2 are set. In divider mode it is 0, whatever M, the lock count or bit 2 hold.
- R9: `clk_sel` always equals the status bit seen on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 3 | Preset select, sampled during reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| clk_sel | output | 1 | 1 = PLL source, 0 = divider source |
| pll_pwr | output | 1 | PLL power enable |
| pll_ratio_x2 | output | 6 | Twice the PLL ratio, 0 when not in force |
| div_by4 | output | 1 | Divider factor select |

## Verification
A write lands on the edge that samples it. The bench drives writes on the falling edge, so the new fields, `pll_pwr`, `div_by4` and a cleared status can be checked on the following falling edge. The rise of `clk_sel` is due on the 16·(N+1)-th rising edge after the write edge. The bench counts rising edges one by one and samples just after each, so any drift of a single edge shows up as a wrong count. Reads are combinational and are sampled a moment after the address is driven, within the same low phase.

// File: rtl/clkmode_ctl.sv
module clkmode_ctl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0058,
  parameter int TICK_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              clk_sel,
  output logic              pll_pwr,
  output logic [5:0]        pll_ratio_x2,
  output logic              div_by4
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [3:0] mul_q;
  logic       half_q;
  logic [7:0] lcnt_q;
  logic       en_q, mode_q, stat_q;
  logic [7:0] timer_q;
  logic       locking;
  logic [PRE_W-1:0] pre_q;

  function automatic logic [15:0] preset(input logic [2:0] p);
    case (p)
      3'd0: preset = 16'h2026;
      3'd1: preset = 16'h1026;
      3'd2: preset = 16'h4026;
      3'd3: preset = 16'h2826;
      3'd4: preset = 16'h0000;
      3'd5: preset = 16'h0800;
      3'd6: preset = 16'h0026;
      default: preset = 16'h3026;
    endcase
  endfunction

  logic [15:0] pv;
  assign pv = preset(mode_pins);

  logic hit, wr_hit, tick;
  assign hit    = bus_sel && (bus_addr == REG_ADDR);
  assign wr_hit = hit && bus_wr;
  assign tick   = locking && en_q && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {mul_q, half_q, lcnt_q, en_q, mode_q} <= pv[15:1];
      stat_q  <= 1'b0;
      locking <= pv[1];
      timer_q <= pv[10:3];
      pre_q   <= '0;
    end else if (wr_hit) begin
      {mul_q, half_q, lcnt_q, en_q, mode_q} <= bus_wdata[15:1];
      stat_q  <= 1'b0;
      locking <= bus_wdata[1];
      timer_q <= bus_wdata[10:3];
      pre_q   <= '0;
    end else if (locking && en_q) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (timer_q == 8'd0) begin
          locking <= 1'b0;
          stat_q  <= 1'b1;
        end else begin
          timer_q <= timer_q - 8'd1;
        end
      end
    end
  end

  logic [5:0] base, ratio;
  logic       reserved;
  assign base     = {2'b00, mul_q} + 6'd1;
  assign ratio    = half_q ? base : {base[4:0], 1'b0};
  assign reserved = half_q && (mul_q == 4'hF);

  assign bus_rdata    = hit ? {mul_q, half_q, lcnt_q, en_q, mode_q, stat_q} : 16'h0000;
  assign clk_sel      = stat_q;
  assign pll_pwr      = mode_q && en_q;
  assign pll_ratio_x2 = (stat_q && !reserved) ? ratio : 6'd0;
  assign div_by4      = !stat_q && half_q;
endmodule

module clkmode_ctl_chk #(
  parameter int PRE_W = 4,
  parameter int TICK_DIV = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_hit,
  input logic [15:0]      bus_wdata,
  input logic             clk_sel,
  input logic             locking,
  input logic [PRE_W-1:0] pre_q,
  input logic             div_by4,
  input logic [5:0]       pll_ratio_x2,
  input logic             pll_pwr
);
  // R5
  div_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !bus_wdata[1] |=> !clk_sel && !locking);
  // R4
  pll_write_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && bus_wdata[1] |=> !clk_sel && locking);
  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> $past(locking) && $past(pre_q) == PRE_W'(TICK_DIV - 1));
  // R7
  div4_only_divider_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> !div_by4);
  // R6
  ratio_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel |-> pll_ratio_x2 == 6'd0);
  // R6
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ratio_x2 <= 6'd32);
  // R8
  pll_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> pll_pwr);
endmodule

bind clkmode_ctl clkmode_ctl_chk #(.PRE_W(PRE_W), .TICK_DIV(TICK_DIV)) u_chk (.*);

// File: tb/clkmode_ctl_bench.sv
module clkmode_ctl_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] REG = 16'h0058;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] mode_pins = 3'd0;
  logic [15:0] bus_addr = 16'h0, bus_wdata = 16'h0, bus_rdata;
  logic clk_sel, pll_pwr, div_by4;
  logic [5:0] pll_ratio_x2;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  clkmode_ctl u_clkmode_ctl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_preset(input int p);
    logic [15:0] t [8] = '{16'h2026, 16'h1026, 16'h4026, 16'h2826,
                           16'h0000, 16'h0800, 16'h0026, 16'h3026};
    return t[p];
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset_presets();
    logic [15:0] d;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      rst_n = 0; mode_pins = 3'(p);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      bus_read(REG, d);
      chk($sformatf("R3 preset pins=%0d", p), d, exp_preset(p));
      chk("R9 status/clk_sel after reset", clk_sel, 1'b0);
    end
  endtask

  task automatic t_reset_lock();
    int n = 0;
    @(negedge clk);
    rst_n = 0; mode_pins = 3'd0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    while (!clk_sel && n < 1000) begin
      @(posedge clk); #1 n++;
    end
    chk("R3 preset lock wait (count 4)", n, 80);
    chk("R6 preset x3 ratio", pll_ratio_x2, 6);
  endtask

  task automatic t_lock_latency(input int cnt);
    int n = 0;
    logic [15:0] d;
    bus_write(REG, 16'h1000 | 16'(cnt << 3) | 16'h0007);
    chk("R4 status clear after PLL write", clk_sel, 1'b0);
    while (!clk_sel && n < 5000) begin
      @(posedge clk); #1 n++;
    end
    chk($sformatf("R4 lock latency count=%0d", cnt), n, 16 * (cnt + 1));
    bus_read(REG, d);
    chk("R9 status bit matches clk_sel", d[0], clk_sel);
    chk("R2 written fields kept, bit0 ignored", d[15:1], (16'h1000 | 16'(cnt << 3) | 16'h0006) >> 1);
  endtask

  task automatic t_ratio(input logic [3:0] m, input logic h, input int exp);
    bus_write(REG, {m, h, 8'd0, 1'b1, 1'b1, 1'b0});
    repeat (15) @(posedge clk);
    #1 chk("R6 ratio zero before lock", pll_ratio_x2, 0);
    @(posedge clk);
    #1 chk("R4 locked at 16", clk_sel, 1'b1);
    chk($sformatf("R6 ratio m=%0d h=%0d", m, h), pll_ratio_x2, exp);
    chk("R7 div_by4 low in PLL", div_by4, 1'b0);
  endtask

  task automatic t_enable_pause();
    bus_write(REG, 16'h0002);
    repeat (40) @(posedge clk);
    #1 chk("R4 no lock while enable clear", clk_sel, 1'b0);
    chk("R8 pwr off with enable clear", pll_pwr, 1'b0);
  endtask

  task automatic t_abort();
    bus_write(REG, 16'h2000 | 16'(5 << 3) | 16'h0006);
    chk("R8 pwr on during lock", pll_pwr, 1'b1);
    repeat (20) @(posedge clk);
    bus_write(REG, 16'hF7FD);
    chk("R5 status low after divider write", clk_sel, 1'b0);
    repeat (200) @(posedge clk);
    #1 chk("R5 no late switch after abort", clk_sel, 1'b0);
    chk("R8 pwr off in divider mode", pll_pwr, 1'b0);
    chk("R6 ratio zero in divider mode", pll_ratio_x2, 0);
    chk("R7 divide by 2", div_by4, 1'b0);
    bus_write(REG, 16'hFFFD);
    chk("R7 divide by 4", div_by4, 1'b1);
    chk("R8 pwr still off", pll_pwr, 1'b0);
  endtask

  task automatic t_locked_to_div();
    t_ratio(4'd3, 1'b0, 8);
    bus_write(REG, 16'h0801);
    chk("R5 immediate leave of PLL", clk_sel, 1'b0);
    chk("R7 div4 after leave", div_by4, 1'b1);
  endtask

  task automatic t_bus_decode();
    logic [15:0] d;
    bus_write(REG, 16'h0001);
    bus_read(REG, d);
    chk("R2 status write ignored", d, 16'h0000);
    bus_write(16'h0059, 16'hFFFE);
    bus_read(REG, d);
    chk("R1 other address write ignored", d, 16'h0000);
    chk("R1 other address no effect on pwr", pll_pwr, 1'b0);
    bus_write(REG, 16'h0800);
    bus_read(16'h0057, d);
    chk("R1 other address reads 0", d, 16'h0000);
    bus_read(REG, d);
    chk("R1 register read", d, 16'h0800);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_presets();
    t_reset_lock();
    t_lock_latency(0);
    t_lock_latency(1);
    t_lock_latency(3);
    t_ratio(4'd0, 1'b1, 1);
    t_ratio(4'd2, 1'b1, 3);
    t_ratio(4'd15, 1'b0, 32);
    t_ratio(4'd0, 1'b0, 2);
    t_ratio(4'd15, 1'b1, 0);
    t_enable_pause();
    t_abort();
    t_locked_to_div();
    t_bus_decode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule